// File: doc/BRIEF.md
# I2C Target Address Decoder and Event FIFO

This block is the target half of an I2C controller. A bit engine in front of it already turns the wires into events: a START (plain or repeated), a STOP, a completed byte, and a request for the next byte while the target is sending. The block decides whether the bus is talking to it. It can compare against two programmable target addresses, each in 7-bit or 10-bit form, and it can accept the general-call address. It returns an ACK or NACK for every byte it owns. Every received byte goes into a small receive FIFO, and the bus conditions of an addressed transaction go in as well.

Each FIFO word carries the byte and a set of tags. The tags tell the host which address took the byte, whether it was ACKed, whether it was the first byte after the address, and whether the entry marks a repeated START or a STOP. A condition entry carries no data, but it still holds a slot, and the host removes it with an ordinary pop. When the master reads, the block holds SCL low until the host writes the byte to send. Sticky interrupt bits report the progress of the transaction.

Top module: `i2c_target_decode`

## Requirements
- R1: After reset the FIFO is empty (`fifo_cnt` 0, `fifo_word` 0), `int_status` is 0, and `ack_vld`, `scl_hold` and `tx_load` are low.
- R2: The first byte after any START is an address byte. When `cfg_dec[2]` is set and `cfg_dec[3]` is clear, address 1 matches in 7-bit form when byte[7:1] equals `cfg_addr1[6:0]`. Address 2 matches the same way through `cfg_dec[4]` and `cfg_dec[5]`. Byte[0]=1 selects a read. A match gives `ack_vld`=1 and `ack_val`=1 one cycle after the byte. When both addresses match, address 1 wins.
- R3: When `cfg_dec[3]` is set (`cfg_dec[5]` for address 2), the address is 10-bit. A header 11110,addr[9:8],0 is ACKed, and the next byte must equal addr[7:0]. After that write header has fully matched, a repeated START followed by the header with byte[0]=1 enters a read. The read header is NACKed when no write header has matched since the last plain START.
- R4: The address byte 0x00 is a general call. It is ACKed when `cfg_dec[1]` is set and `bus_loop` is low, or when `cfg_dec[0]` is set and `bus_loop` is high.
- R5: An address byte that matches nothing is NACKed. After it, no byte produces `ack_vld` and no entry is pushed until the next START.
- R6: During a write phase each data byte is pushed. It is ACKed only when the receive-enable bit of its target is set: `cfg_rx[0]` for address 1, `cfg_rx[1]` for address 2, `cfg_rx[2]` for general call. A byte that arrives with the FIFO full is NACKed and dropped.
- R7: A FIFO word holds the data in [7:0]. Bit 8 marks address 1 and bit 9 marks address 2; a general-call byte sets both. Bit 10 means ACK was sent. Bit 11 is always 0. Bit 12 marks the first data byte after the address. Bit 13 marks a repeated START and bit 14 marks a STOP.
- R8: A repeated START or a STOP inside an addressed transaction pushes a word with data 0 and only its own condition bit set. Outside such a transaction these conditions push nothing. Every word leaves the FIFO only through `host_pop`.
- R9: Each `int_status` bit is sticky, is cleared by writing 1 through `int_clr`, and a new event wins over a clear in the same cycle. The bits mean:
  - bit 0: word pushed.
  - bit 1: a write phase ended by a STOP or a repeated START.
  - bit 2: read addressed after a plain START.
  - bit 3: read addressed after a repeated START.
  - bit 4: `bus_rd_req` during a read.
  - bit 5: a read ended while host data was still awaited.
  - bits 7:6: always 0.
- R10: `scl_hold` rises when a read is addressed or when `bus_rd_req` arrives during a read, and stays high until `host_wr`. In the cycle after that `host_wr`, `tx_load` pulses with `tx_byte` set to `host_wdata`. A `host_wr` while `scl_hold` is low has no effect.
- R11: The FIFO returns words in push order and `fifo_cnt` never exceeds DEPTH. A `host_pop` with the FIFO empty does nothing, and `fifo_word` reads 0 while empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_dec | input | 6 | Address decode control: general-call accept for loopback and for external masters, enable and 10-bit mode for each address |
| cfg_rx | input | 3 | Receive ACK enables for address 1, address 2 and general call |
| cfg_addr1 | input | 10 | Target address 1 |
| cfg_addr2 | input | 10 | Target address 2 |
| bus_start | input | 1 | START or repeated START seen (pulse) |
| bus_stop | input | 1 | STOP seen (pulse) |
| bus_byte_vld | input | 1 | A byte was received (pulse) |
| bus_byte | input | 8 | Received byte |
| bus_loop | input | 1 | The current transaction comes from the controller's own master |
| bus_rd_req | input | 1 | Master ACKed and wants the next read byte (pulse) |
| host_pop | input | 1 | Pop the FIFO head |
| host_wr | input | 1 | Host writes a byte to transmit |
| host_wdata | input | 8 | Byte to transmit |
| int_clr | input | 8 | Write-1-to-clear for `int_status` |
| ack_vld | output | 1 | An ACK decision is valid (pulse) |
| ack_val | output | 1 | 1 = ACK, 0 = NACK |
| scl_hold | output | 1 | Stretch SCL while waiting for host read data |
| tx_load | output | 1 | `tx_byte` is valid for the bit engine (pulse) |
| tx_byte | output | 8 | Byte to transmit |
| fifo_word | output | 15 | FIFO head word, tags and data |
| fifo_cnt | output | $clog2(DEPTH+1) | FIFO fill level |
| int_status | output | 8 | Sticky interrupt status |

## Verification
The bench builds the block with DEPTH 4. At that depth a single five-byte write fills the FIFO, and the same write shows the NACK-and-drop of the overflow byte and the loss of the STOP entry that follows it. That depth also makes the pointers wrap several times during ordinary traffic, so ordering across the wrap is covered. The stimulus covers several paths:
- a 10-bit write header, a repeated START and a 10-bit read header in one transaction;
- general calls from both sources;
- an unmatched address followed by bytes that must be ignored;
- a STOP that cancels a read while SCL is stretched.

// File: rtl/i2c_target_decode.sv
module i2c_target_decode #(
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [5:0]                   cfg_dec,
  input  logic [2:0]                   cfg_rx,
  input  logic [9:0]                   cfg_addr1,
  input  logic [9:0]                   cfg_addr2,
  input  logic                         bus_start,
  input  logic                         bus_stop,
  input  logic                         bus_byte_vld,
  input  logic [7:0]                   bus_byte,
  input  logic                         bus_loop,
  input  logic                         bus_rd_req,
  input  logic                         host_pop,
  input  logic                         host_wr,
  input  logic [7:0]                   host_wdata,
  input  logic [7:0]                   int_clr,
  output logic                         ack_vld,
  output logic                         ack_val,
  output logic                         scl_hold,
  output logic                         tx_load,
  output logic [7:0]                   tx_byte,
  output logic [14:0]                  fifo_word,
  output logic [$clog2(DEPTH+1)-1:0]   fifo_cnt,
  output logic [7:0]                   int_status
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ADDR10, S_WR, S_RD} st_t;

  st_t         st;
  logic [1:0]  sel, arm, pend;
  logic        first, busy, rep;
  logic [14:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  wire full   = (cnt == CW'(DEPTH));
  wire empty  = (cnt == '0);
  wire in_txn = (st == S_WR) || (st == S_RD);
  wire hdr    = (bus_byte[7:3] == 5'b11110);

  wire m7_1 = cfg_dec[2] & ~cfg_dec[3] & (bus_byte[7:1] == cfg_addr1[6:0]);
  wire m7_2 = cfg_dec[4] & ~cfg_dec[5] & (bus_byte[7:1] == cfg_addr2[6:0]);
  wire h_1  = cfg_dec[2] & cfg_dec[3] & hdr & (bus_byte[2:1] == cfg_addr1[9:8]);
  wire h_2  = cfg_dec[4] & cfg_dec[5] & hdr & (bus_byte[2:1] == cfg_addr2[9:8]);
  wire gc   = (bus_byte == 8'h00) & (bus_loop ? cfg_dec[0] : cfg_dec[1]);
  wire rh_1 = h_1 & bus_byte[0] & arm[0];
  wire rh_2 = h_2 & bus_byte[0] & arm[1];
  wire [1:0] wrh = {h_2 & ~bus_byte[0], h_1 & ~bus_byte[0]};
  wire lo_1 = pend[0] & (bus_byte == cfg_addr1[7:0]);
  wire lo_2 = pend[1] & (bus_byte == cfg_addr2[7:0]);
  wire rx_ok = ((sel == 2'd1) & cfg_rx[0]) | ((sel == 2'd2) & cfg_rx[1]) |
               ((sel == 2'd3) & cfg_rx[2]);

  logic [1:0] a_sel;
  logic       a_rd;
  always_comb begin
    a_sel = 2'd0;
    a_rd  = 1'b0;
    if (m7_1)      begin a_sel = 2'd1; a_rd = bus_byte[0]; end
    else if (rh_1) begin a_sel = 2'd1; a_rd = 1'b1; end
    else if (m7_2) begin a_sel = 2'd2; a_rd = bus_byte[0]; end
    else if (rh_2) begin a_sel = 2'd2; a_rd = 1'b1; end
    else if (gc)   a_sel = 2'd3;
  end

  wire data_push = bus_byte_vld & (st == S_WR);
  wire cond_push = (bus_start | bus_stop) & in_txn;
  wire push      = (data_push | cond_push) & ~full;
  wire pop       = host_pop & ~empty;
  wire [14:0] push_word = data_push ?
    {2'b00, first, 1'b0, rx_ok & ~full, sel[1], sel[0], bus_byte} :
    {bus_stop, bus_start, 13'd0};
  wire rd_hit = bus_byte_vld & (st == S_ADDR) & (a_sel != 2'd0) & a_rd;

  wire [7:0] int_set = {2'b00,
                        (bus_start | bus_stop) & (st == S_RD) & scl_hold,
                        bus_rd_req & (st == S_RD),
                        rd_hit & rep,
                        rd_hit & ~rep,
                        (bus_start | bus_stop) & (st == S_WR),
                        push};

  always_ff @(posedge clk) if (push) mem[wp] <= push_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sel <= '0; arm <= '0; pend <= '0;
      first <= 1'b0; busy <= 1'b0; rep <= 1'b0;
      wp <= '0; rp <= '0; cnt <= '0;
      ack_vld <= 1'b0; ack_val <= 1'b0; scl_hold <= 1'b0;
      tx_load <= 1'b0; tx_byte <= '0; int_status <= '0;
    end else begin
      ack_vld <= 1'b0;
      tx_load <= 1'b0;
      int_status <= (int_status & ~int_clr) | int_set;
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
      if (host_wr && scl_hold) begin
        tx_load  <= 1'b1;
        tx_byte  <= host_wdata;
        scl_hold <= 1'b0;
      end
      if (bus_stop) begin
        st <= S_IDLE; busy <= 1'b0; arm <= '0; scl_hold <= 1'b0;
      end else if (bus_start) begin
        st <= S_ADDR; busy <= 1'b1; rep <= busy; scl_hold <= 1'b0;
        if (!busy) arm <= '0;
      end else if (bus_byte_vld) begin
        case (st)
          S_ADDR: begin
            ack_vld <= 1'b1;
            if (a_sel != 2'd0) begin
              ack_val <= 1'b1; sel <= a_sel; first <= 1'b1;
              st <= a_rd ? S_RD : S_WR;
              if (a_rd) scl_hold <= 1'b1;
            end else if (wrh != 2'd0) begin
              ack_val <= 1'b1; pend <= wrh; st <= S_ADDR10;
            end else begin
              ack_val <= 1'b0; st <= S_IDLE;
            end
          end
          S_ADDR10: begin
            ack_vld <= 1'b1;
            if (lo_1 || lo_2) begin
              ack_val <= 1'b1; first <= 1'b1; st <= S_WR;
              sel <= lo_1 ? 2'd1 : 2'd2;
              arm <= arm | (lo_1 ? 2'b01 : 2'b10);
            end else begin
              ack_val <= 1'b0; st <= S_IDLE;
            end
          end
          S_WR: begin
            ack_vld <= 1'b1;
            ack_val <= rx_ok & ~full;
            if (!full) first <= 1'b0;
          end
          default: ;
        endcase
      end else if (bus_rd_req && st == S_RD) begin
        scl_hold <= 1'b1;
      end
    end
  end

  assign fifo_cnt  = cnt;
  assign fifo_word = empty ? 15'd0 : mem[rp];

  p_hold_until_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold && !host_wr && !bus_start && !bus_stop |=> scl_hold);
  p_load_follows_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold && host_wr |=> tx_load && tx_byte == $past(host_wdata));
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));
  p_sticky_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((int_status & $past(int_status & ~int_clr)) == $past(int_status & ~int_clr)));
  p_ack_needs_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |-> $past(bus_byte_vld));
  p_idle_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE && bus_byte_vld && !bus_start && !bus_stop |=> !ack_vld);
endmodule

// File: tb/i2c_target_decode_tb.sv
`timescale 1ns/1ps
module i2c_target_decode_tb;
  localparam int DEPTH = 4;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic [5:0] cfg_dec = 6'h36;
  logic [2:0] cfg_rx = 3'b111;
  logic [9:0] cfg_addr1 = 10'h02A, cfg_addr2 = 10'h1B5;
  logic bus_start = 0, bus_stop = 0, bus_byte_vld = 0, bus_loop = 0, bus_rd_req = 0;
  logic [7:0] bus_byte = 0;
  logic host_pop = 0, host_wr = 0;
  logic [7:0] host_wdata = 0, int_clr = 0;
  logic ack_vld, ack_val, scl_hold, tx_load;
  logic [7:0] tx_byte, int_status;
  logic [14:0] fifo_word;
  logic [CW-1:0] fifo_cnt;

  i2c_target_decode #(.DEPTH(DEPTH)) u_dut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_st = 0;  // 0 idle,1 addr,2 addr10,3 write,4 read
  int m_sel = 0;
  bit [1:0] m_arm = 0, m_pend = 0;
  bit m_first = 0, m_busy = 0, m_rep = 0, m_hold = 0, m_ackv = 0, m_ack = 0, m_txl = 0;
  bit [7:0] m_txb = 0, m_int = 0, st_set;
  bit [14:0] q[$];
  bit m_full, m_empty, m_push, m_okrx, n_hold;
  bit [14:0] m_w;
  int who;
  bit rdir;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_sel = 0; m_arm = 0; m_pend = 0; m_first = 0; m_busy = 0; m_rep = 0;
      m_hold = 0; m_ackv = 0; m_ack = 0; m_txl = 0; m_txb = 0; m_int = 0; q.delete();
    end else begin
      m_full = (q.size() == DEPTH);
      m_empty = (q.size() == 0);
      st_set = 0; m_push = 0; m_w = 0; m_ackv = 0; m_txl = 0;
      m_okrx = (m_sel == 1 && cfg_rx[0]) || (m_sel == 2 && cfg_rx[1]) || (m_sel == 3 && cfg_rx[2]);
      n_hold = m_hold;
      if (host_wr && m_hold) begin m_txl = 1; m_txb = host_wdata; n_hold = 0; end
      if (bus_stop || bus_start) begin
        if (m_st == 3 || m_st == 4) begin
          m_push = 1; m_w = bus_stop ? 15'h4000 : 15'h2000;
          if (m_st == 3) st_set[1] = 1;
          if (m_st == 4 && m_hold) st_set[5] = 1;
        end
        n_hold = 0;
        if (bus_stop) begin m_st = 0; m_busy = 0; m_arm = 0; end
        else begin m_rep = m_busy; if (!m_busy) m_arm = 0; m_busy = 1; m_st = 1; end
      end else if (bus_byte_vld) begin
        if (m_st == 1) begin
          m_ackv = 1; who = 0; rdir = 0;
          if (cfg_dec[2] && !cfg_dec[3] && bus_byte[7:1] == cfg_addr1[6:0]) begin who = 1; rdir = bus_byte[0]; end
          else if (cfg_dec[2] && cfg_dec[3] && bus_byte == {5'b11110, cfg_addr1[9:8], 1'b1} && m_arm[0]) begin who = 1; rdir = 1; end
          else if (cfg_dec[4] && !cfg_dec[5] && bus_byte[7:1] == cfg_addr2[6:0]) begin who = 2; rdir = bus_byte[0]; end
          else if (cfg_dec[4] && cfg_dec[5] && bus_byte == {5'b11110, cfg_addr2[9:8], 1'b1} && m_arm[1]) begin who = 2; rdir = 1; end
          else if (bus_byte == 0 && (bus_loop ? cfg_dec[0] : cfg_dec[1])) who = 3;
          if (who != 0) begin
            m_ack = 1; m_sel = who; m_first = 1;
            if (rdir) begin m_st = 4; n_hold = 1; st_set[m_rep ? 3 : 2] = 1; end else m_st = 3;
          end else begin
            m_pend[0] = cfg_dec[2] && cfg_dec[3] && bus_byte == {5'b11110, cfg_addr1[9:8], 1'b0};
            m_pend[1] = cfg_dec[4] && cfg_dec[5] && bus_byte == {5'b11110, cfg_addr2[9:8], 1'b0};
            m_ack = (m_pend != 0);
            m_st = m_ack ? 2 : 0;
          end
        end else if (m_st == 2) begin
          m_ackv = 1;
          if (m_pend[0] && bus_byte == cfg_addr1[7:0]) begin m_ack = 1; m_sel = 1; m_arm[0] = 1; m_first = 1; m_st = 3; end
          else if (m_pend[1] && bus_byte == cfg_addr2[7:0]) begin m_ack = 1; m_sel = 2; m_arm[1] = 1; m_first = 1; m_st = 3; end
          else begin m_ack = 0; m_st = 0; end
        end else if (m_st == 3) begin
          m_ackv = 1; m_ack = m_okrx && !m_full; m_push = 1;
          m_w = {2'b00, m_first, 1'b0, m_okrx && !m_full, m_sel[1], m_sel[0], bus_byte};
          if (!m_full) m_first = 0;
        end
      end else if (bus_rd_req && m_st == 4) begin
        n_hold = 1; st_set[4] = 1;
      end
      if (m_push && !m_full) begin q.push_back(m_w); st_set[0] = 1; end
      if (host_pop && !m_empty) void'(q.pop_front());
      m_hold = n_hold;
      m_int = (m_int & ~int_clr) | st_set;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk(ack_vld == m_ackv, "R2,R5,R6 ack_vld", ack_vld, m_ackv);
    if (m_ackv) chk(ack_val == m_ack, "R2,R3,R6 ack_val", ack_val, m_ack);
    chk(scl_hold == m_hold, "R10 scl_hold", scl_hold, m_hold);
    chk(tx_load == m_txl, "R10 tx_load", tx_load, m_txl);
    if (m_txl) chk(tx_byte == m_txb, "R10 tx_byte", tx_byte, m_txb);
    chk(fifo_cnt == q.size(), "R8,R11 fifo_cnt", fifo_cnt, q.size());
    chk(fifo_word == (q.size() ? q[0] : 15'd0), "R7,R11 fifo_word", fifo_word, q.size() ? q[0] : 15'd0);
    chk(int_status == m_int, "R9 int_status", int_status, m_int);
  end

  task automatic idle(input int n); repeat (n) @(negedge clk); endtask
  task automatic start_c(); bus_start = 1; @(negedge clk); bus_start = 0; endtask
  task automatic stop_c();  bus_stop = 1;  @(negedge clk); bus_stop = 0;  endtask
  task automatic byte_c(input logic [7:0] b, output bit av, output bit a);
    bus_byte_vld = 1; bus_byte = b; @(negedge clk); av = ack_vld; a = ack_val; bus_byte_vld = 0;
  endtask
  task automatic pop_c(); host_pop = 1; @(negedge clk); host_pop = 0; endtask
  task automatic wr_c(input logic [7:0] d, output bit ld, output logic [7:0] tb);
    host_wr = 1; host_wdata = d; @(negedge clk); ld = tx_load; tb = tx_byte; host_wr = 0;
  endtask
  task automatic clr_c(input logic [7:0] m); int_clr = m; @(negedge clk); int_clr = 0; endtask
  task automatic drain(); while (fifo_cnt != 0) pop_c(); endtask

  initial begin
    bit av, a, ld;
    logic [7:0] tb;
    idle(3);
    chk(fifo_cnt == 0 && fifo_word == 0, "R1 fifo empty", fifo_cnt, 0);
    chk(int_status == 0, "R1 int_status", int_status, 0);
    chk(!ack_vld && !scl_hold && !tx_load, "R1 outputs low", {ack_vld, scl_hold, tx_load}, 0);
    rst_n = 1; idle(2);

    // 7-bit write to address 1
    start_c(); byte_c(8'h54, av, a);
    chk(av && a, "R2 address ACK", {av, a}, 2'b11);
    byte_c(8'hA1, av, a); byte_c(8'hA2, av, a); stop_c(); idle(1);
    chk(fifo_word == 15'h15A1, "R7 first data word", fifo_word, 15'h15A1);
    pop_c(); chk(fifo_word == 15'h05A2, "R7 second data word", fifo_word, 15'h05A2);
    pop_c(); chk(fifo_word == 15'h4000, "R8 stop entry", fifo_word, 15'h4000);
    pop_c(); idle(1);

    // overflow
    start_c(); byte_c(8'h54, av, a);
    for (int i = 0; i < 4; i++) byte_c(8'hB0 + 8'(i), av, a);
    byte_c(8'hB4, av, a);
    chk(av && !a, "R6 full FIFO NACK", {av, a}, 2'b10);
    stop_c(); chk(fifo_cnt == 4, "R6 overflow dropped", fifo_cnt, 4);
    drain();

    // unmatched address
    start_c(); byte_c(8'h60, av, a);
    chk(av && !a, "R5 unmatched NACK", {av, a}, 2'b10);
    byte_c(8'h11, av, a);
    chk(!av, "R5 ignored after NACK", av, 0);
    stop_c(); chk(fifo_cnt == 0, "R5 no entry", fifo_cnt, 0);

    // 10-bit write, repeated start, 10-bit read
    clr_c(8'hFF);
    start_c(); byte_c(8'hF2, av, a);
    chk(av && a, "R3 10-bit header ACK", {av, a}, 2'b11);
    byte_c(8'hB5, av, a);
    chk(av && a, "R3 10-bit low byte ACK", {av, a}, 2'b11);
    byte_c(8'h33, av, a);
    chk(fifo_word == 15'h1633, "R7 address 2 word", fifo_word, 15'h1633);
    start_c(); byte_c(8'hF3, av, a);
    chk(av && a && scl_hold, "R3 10-bit read entered", {av, a, scl_hold}, 3'b111);
    idle(2);
    chk(scl_hold, "R10 stretch while waiting", scl_hold, 1);
    wr_c(8'h5C, ld, tb);
    chk(ld && tb == 8'h5C, "R10 tx load", {ld, tb}, {1'b1, 8'h5C});
    bus_rd_req = 1; @(negedge clk); bus_rd_req = 0;
    stop_c();
    chk(int_status == 8'h3B, "R9 status after read cancel", int_status, 8'h3B);
    drain();

    // read header without a prior write header
    start_c(); byte_c(8'hF3, av, a);
    chk(av && !a, "R3 unarmed read header NACK", {av, a}, 2'b10);
    stop_c();

    // 7-bit read from address 1
    clr_c(8'hFF);
    start_c(); byte_c(8'h55, av, a);
    chk(int_status[2] && scl_hold, "R9 read request after START", int_status, 8'h04);
    wr_c(8'h77, ld, tb); stop_c(); drain();

    // general call from both sources
    start_c(); byte_c(8'h00, av, a);
    chk(av && a, "R4 external general call ACK", {av, a}, 2'b11);
    byte_c(8'h42, av, a);
    chk(fifo_word == 15'h1742, "R4 general call word", fifo_word, 15'h1742);
    stop_c(); drain();
    bus_loop = 1;
    start_c(); byte_c(8'h00, av, a);
    chk(av && !a, "R4 loopback general call NACK", {av, a}, 2'b10);
    stop_c(); bus_loop = 0;

    // receive ACK disabled for address 1
    cfg_rx = 3'b110;
    start_c(); byte_c(8'h54, av, a); byte_c(8'h99, av, a);
    chk(av && !a, "R6 rx disabled NACK", {av, a}, 2'b10);
    chk(fifo_word == 15'h1199, "R6 NACKed byte stored", fifo_word, 15'h1199);
    stop_c(); drain(); cfg_rx = 3'b111;

    // both addresses 7-bit and equal: address 1 wins
    cfg_dec = 6'h16; cfg_addr2 = 10'h02A;
    start_c(); byte_c(8'h54, av, a); byte_c(8'h10, av, a);
    chk(fifo_word == 15'h1510, "R2 address 1 priority", fifo_word, 15'h1510);
    stop_c(); drain();

    // stray write, clear, empty pop
    wr_c(8'hEE, ld, tb);
    idle(1); chk(!tx_load, "R10 write without request ignored", tx_load, 0);
    clr_c(8'hFF);
    chk(int_status == 0, "R9 write-1 clear", int_status, 0);
    pop_c(); chk(fifo_cnt == 0 && fifo_word == 0, "R11 pop on empty", fifo_cnt, 0);
    idle(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule